// File: doc/BRIEF.md
# S/PDIF Biphase-Mark Transmitter

This block turns a stream of stereo PCM sample pairs into a single-bit S/PDIF line. Each stereo pair fills one frame, which holds two 32-slot subframes: left first, then right. Each subframe opens with a sync preamble. The 24-bit audio word follows, and the subframe closes with the validity, user, channel-status and parity bits. Every slot after the preamble is sent as a biphase-mark cell. The line advances by one half-cell on each enabled master-clock edge. A ratio select sets how many master clocks make up one half-cell, so the same logic serves master clocks of 128, 256 or 512 times the sample rate.

The channel-status stream comes from a fixed 28-bit template, with one bit sent per frame. The template carries a left/right code and a code for the configured sample rate. A block holds 192 frames and is marked by a distinct preamble on its first left subframe. The upstream source offers left and right together. The block takes the pair in the clock cycle just before a frame begins. If no pair is offered at that point, the frame carries silence and an underrun flag is raised for that frame.

Top module: `spdif_tx`

## Requirements
- R1: While reset is asserted, `spdif_out`, `pair_ready` and `underrun` are low. After reset, `spdif_out` stays low until the first half-cell of a block-start (B) preamble is driven.
- R2: `ratio_sel` values 0, 1 and 2 make every half-cell last exactly 1, 2 and 4 master clocks, respectively. `spdif_out` does not change inside a half-cell.
- R3: `pair_ready` is high for exactly one master clock per frame. That clock is the last clock before the frame's first half-cell. A pair is taken at that edge when `pair_valid` is high.
- R4: Bits 7:0 of `left_in` and `right_in` are ignored. The transmitted audio word is bits 31:8.
- R5: Slots 0 to 3 of each subframe are sent as raw levels, first element first. The B pattern 11101000 goes on the left subframe of frame 0 of each 192-frame block. The M pattern 11100010 goes on every other left subframe, and the W pattern 11100100 on every right subframe. The line is low before every preamble.
- R6: Slots 4 to 27 carry the 24 audio bits, least significant bit first.
- R7: Every cell in slots 4 to 31 begins with a level change. A cell adds a second change at mid-cell only when its bit is 1.
- R8: The validity bit (slot 28) and the user bit (slot 29) are always 0.
- R9: Slot 30 of frame f (counted from 0 within the block) carries bit f of the word {4'h0, n, c, 16'h07A4}, where c is 1 for left and 2 for right. Frames 28 to 191 carry 0 in this slot. A block is 192 frames long.
- R10: `rate_sel` values 0 to 5 (44.1, 48, 88.2, 96, 176.4 and 192 kHz) give the rate code n = 0, 2, 8, 10, 12 and 14.
- R11: Slot 31 makes the count of ones in slots 4 to 31 even.
- R12: If `pair_valid` is low while `pair_ready` is high, both subframes of that frame carry all-zero audio and `underrun` is high for that frame. `underrun` drops again at the next frame whose pair is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (128, 256 or 512 times the sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ratio_sel | input | 2 | Master clocks per half-cell: 0 gives 1, 1 gives 2, 2 gives 4 |
| rate_sel | input | 3 | Configured sample rate, 0 to 5, used for the channel-status rate code |
| pair_valid | input | 1 | A stereo pair is offered |
| left_in | input | 32 | Left sample, audio left-aligned in bits 31:8 |
| right_in | input | 32 | Right sample, audio left-aligned in bits 31:8 |
| pair_ready | output | 1 | Pair accepted at this clock edge when `pair_valid` is high |
| underrun | output | 1 | The current frame carries silence because no pair was offered |
| spdif_out | output | 1 | Biphase-mark coded S/PDIF line |

## Verification
A wrong half-cell position shows at once. The next half-cell after the fault either breaks a preamble pattern or misses the level change at a cell start. An error in the frame counter goes unseen until the next channel-status bit in slot 30, or until the B preamble lands on the wrong frame. That can take up to a full 192-frame block, so one configuration runs past the block boundary. An error in the captured samples first shows in slot 4 of the frame that used them and is then confirmed by parity in slot 31. An error in the handshake shows one clock before the frame starts, as a `pair_ready` pulse at the wrong time.

// File: rtl/spdif_tx_pkg.sv
`timescale 1ns/1ps
package spdif_tx_pkg;
  localparam int WORD_W       = 32;
  localparam int AUDIO_W      = 24;
  localparam int FRAME_HALVES = 128;
  localparam int BLOCK_FRAMES = 192;
  localparam int CS_USED      = 28;

  typedef enum logic [1:0] {SYNC_BLK, SYNC_LEFT, SYNC_RIGHT} sync_e;

  // Raw half-cell levels of a preamble, first element in bit 7.
  function automatic logic [7:0] sync_levels(sync_e kind);
    case (kind)
      SYNC_BLK:  return 8'b1110_1000;
      SYNC_LEFT: return 8'b1110_0010;
      default:   return 8'b1110_0100;
    endcase
  endfunction

  function automatic logic [3:0] rate_code(logic [2:0] sel);
    case (sel)
      3'd1:    return 4'd2;
      3'd2:    return 4'd8;
      3'd3:    return 4'd10;
      3'd4:    return 4'd12;
      3'd5:    return 4'd14;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [CS_USED-1:0] status_word(logic is_right, logic [3:0] rate);
    return {4'h0, rate, (is_right ? 4'h2 : 4'h1), 16'h07A4};
  endfunction
endpackage

// File: rtl/spdif_half_timer.sv
`timescale 1ns/1ps
module spdif_half_timer #(
  parameter int FRAME_HALVES = spdif_tx_pkg::FRAME_HALVES,
  parameter int BLOCK_FRAMES = spdif_tx_pkg::BLOCK_FRAMES,
  localparam int PW = $clog2(FRAME_HALVES),
  localparam int FW = $clog2(BLOCK_FRAMES)
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [1:0]    ratio_sel,
  output logic          tick,
  output logic [PW-1:0] pos,
  output logic [FW-1:0] frame
);
  logic [1:0]    div_q, div_d, lim;
  logic [PW-1:0] pos_q, pos_d;
  logic [FW-1:0] frame_q, frame_d;

  always_comb begin
    case (ratio_sel)
      2'd0:    lim = 2'd0;
      2'd1:    lim = 2'd1;
      default: lim = 2'd3;
    endcase
  end

  assign tick = srst_n && (div_q >= lim);

  always_comb begin
    div_d   = div_q;
    pos_d   = pos_q;
    frame_d = frame_q;
    if (tick) begin
      div_d = '0;
      if (pos_q == PW'(FRAME_HALVES - 1)) begin
        pos_d   = '0;
        frame_d = (frame_q == FW'(BLOCK_FRAMES - 1)) ? '0 : frame_q + 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end else begin
      div_d = div_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      div_q   <= '0;
      pos_q   <= '0;
      frame_q <= '0;
    end else begin
      div_q   <= div_d;
      pos_q   <= pos_d;
      frame_q <= frame_d;
    end
  end

  assign pos   = pos_q;
  assign frame = frame_q;
endmodule

// File: rtl/spdif_sample_latch.sv
`timescale 1ns/1ps
module spdif_sample_latch #(
  parameter int WORD_W  = spdif_tx_pkg::WORD_W,
  parameter int AUDIO_W = spdif_tx_pkg::AUDIO_W
) (
  input  logic               clk,
  input  logic               srst_n,
  input  logic               load,
  input  logic               valid,
  input  logic [WORD_W-1:0]  left_in,
  input  logic [WORD_W-1:0]  right_in,
  output logic [AUDIO_W-1:0] left_q,
  output logic [AUDIO_W-1:0] right_q,
  output logic               starved
);
  logic [AUDIO_W-1:0] left_d, right_d, left_r, right_r;
  logic               starved_d, starved_r;

  always_comb begin
    left_d    = left_r;
    right_d   = right_r;
    starved_d = starved_r;
    if (load) begin
      left_d    = valid ? left_in[WORD_W-1 -: AUDIO_W]  : '0;
      right_d   = valid ? right_in[WORD_W-1 -: AUDIO_W] : '0;
      starved_d = !valid;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      left_r    <= '0;
      right_r   <= '0;
      starved_r <= 1'b0;
    end else begin
      left_r    <= left_d;
      right_r   <= right_d;
      starved_r <= starved_d;
    end
  end

  assign left_q  = left_r;
  assign right_q = right_r;
  assign starved = starved_r;
endmodule

// File: rtl/spdif_slot_mux.sv
`timescale 1ns/1ps
module spdif_slot_mux
  import spdif_tx_pkg::*;
#(
  parameter int AUDIO_W      = spdif_tx_pkg::AUDIO_W,
  parameter int FRAME_HALVES = spdif_tx_pkg::FRAME_HALVES,
  parameter int BLOCK_FRAMES = spdif_tx_pkg::BLOCK_FRAMES,
  localparam int PW = $clog2(FRAME_HALVES),
  localparam int FW = $clog2(BLOCK_FRAMES),
  localparam int SW = PW - 2
) (
  input  logic [PW-1:0]      pos,
  input  logic [FW-1:0]      frame,
  input  logic [AUDIO_W-1:0] left_q,
  input  logic [AUDIO_W-1:0] right_q,
  input  logic [2:0]         rate_sel,
  output logic               in_sync,
  output logic               sync_lvl,
  output logic               second_half,
  output logic               cell_bit
);
  logic [SW-1:0]      slot;
  logic               is_right, cs_bit, par_bit;
  logic [AUDIO_W-1:0] audio;
  logic [CS_USED-1:0] csw;
  logic [7:0]         pat;
  sync_e              kind;

  assign is_right    = pos[PW-1];
  assign slot        = pos[PW-2:1];
  assign second_half = pos[0];
  assign audio       = is_right ? right_q : left_q;
  assign in_sync     = (slot < SW'(4));

  always_comb begin
    csw    = status_word(is_right, rate_code(rate_sel));
    cs_bit = (frame < FW'(CS_USED)) ? csw[frame[4:0]] : 1'b0;
  end

  assign par_bit = ^{audio, cs_bit};

  always_comb begin
    if (is_right)            kind = SYNC_RIGHT;
    else if (frame == '0)    kind = SYNC_BLK;
    else                     kind = SYNC_LEFT;
    pat      = sync_levels(kind);
    sync_lvl = pat[3'd7 - {slot[1:0], second_half}];
  end

  always_comb begin
    if (slot <= SW'(AUDIO_W + 3)) cell_bit = audio[slot - SW'(4)];
    else if (slot == SW'(30))     cell_bit = cs_bit;
    else if (slot == SW'(31))     cell_bit = par_bit;
    else                          cell_bit = 1'b0;
  end
endmodule

// File: rtl/spdif_bmc_line.sv
`timescale 1ns/1ps
module spdif_bmc_line (
  input  logic clk,
  input  logic srst_n,
  input  logic tick,
  input  logic in_sync,
  input  logic sync_lvl,
  input  logic second_half,
  input  logic cell_bit,
  output logic line
);
  logic line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (tick) begin
      if (in_sync)           line_d = sync_lvl;
      else if (!second_half) line_d = ~line_q;
      else if (cell_bit)     line_d = ~line_q;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) line_q <= 1'b0;
    else         line_q <= line_d;
  end

  assign line = line_q;
endmodule

// File: rtl/spdif_tx.sv
`timescale 1ns/1ps
module spdif_tx
  import spdif_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ratio_sel,
  input  logic [2:0]        rate_sel,
  input  logic              pair_valid,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  output logic              pair_ready,
  output logic              underrun,
  output logic              spdif_out
);
  localparam int PW = $clog2(FRAME_HALVES);
  localparam int FW = $clog2(BLOCK_FRAMES);

  logic [1:0]         rs_q;
  logic               srst_n, tick, in_sync, sync_lvl, second_half, cell_bit;
  logic [PW-1:0]      pos;
  logic [FW-1:0]      frame;
  logic [AUDIO_W-1:0] left_q, right_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  spdif_half_timer u_tim (
    .clk(clk), .srst_n(srst_n), .ratio_sel(ratio_sel),
    .tick(tick), .pos(pos), .frame(frame)
  );

  assign pair_ready = tick && (pos == '0);

  spdif_sample_latch u_lat (
    .clk(clk), .srst_n(srst_n), .load(pair_ready), .valid(pair_valid),
    .left_in(left_in), .right_in(right_in),
    .left_q(left_q), .right_q(right_q), .starved(underrun)
  );

  spdif_slot_mux u_mux (
    .pos(pos), .frame(frame), .left_q(left_q), .right_q(right_q),
    .rate_sel(rate_sel), .in_sync(in_sync), .sync_lvl(sync_lvl),
    .second_half(second_half), .cell_bit(cell_bit)
  );

  spdif_bmc_line u_bmc (
    .clk(clk), .srst_n(srst_n), .tick(tick), .in_sync(in_sync),
    .sync_lvl(sync_lvl), .second_half(second_half), .cell_bit(cell_bit),
    .line(spdif_out)
  );
endmodule

// File: rtl/spdif_tx_chk.sv
`timescale 1ns/1ps
module spdif_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [6:0]  pos,
  input logic        pair_ready,
  input logic        pair_valid,
  input logic        underrun,
  input logic        spdif_out,
  input logic [23:0] left_q,
  input logic [31:0] left_in
);
  // R3
  ready_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready |=> (pos == 7'd1));

  // R12
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_ready && !pair_valid) |=> underrun);

  // R12
  underrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_ready && pair_valid) |=> !underrun);

  // R4
  capture_high_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_ready && pair_valid) |=> (left_q == $past(left_in[31:8])));

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(spdif_out));

  // R7
  cell_start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (pos[5:3] != 3'd0) && !pos[0]) |=> (spdif_out != $past(spdif_out)));
endmodule

bind spdif_tx spdif_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pos(pos),
  .pair_ready(pair_ready), .pair_valid(pair_valid), .underrun(underrun),
  .spdif_out(spdif_out), .left_q(left_q), .left_in(left_in)
);

// File: tb/sim_spdif_tx.sv
`timescale 1ns/1ps
module sim_spdif_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ratio_sel = 2'd0;
  logic [2:0]  rate_sel = 3'd0;
  logic        pair_valid = 1'b0;
  logic [31:0] left_in = '0;
  logic [31:0] right_in = '0;
  logic        pair_ready, underrun, spdif_out;

  int n_checks = 0;
  int n_fail   = 0;
  int src_frame = 0;
  bit src_en = 1'b0;

  always #2.5 clk = ~clk;

  spdif_tx u0 (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .rate_sel(rate_sel),
    .pair_valid(pair_valid), .left_in(left_in), .right_in(right_in),
    .pair_ready(pair_ready), .underrun(underrun), .spdif_out(spdif_out)
  );

  function automatic bit is_under(int f);
    return (f == 5) || (f == 6);
  endfunction

  function automatic logic [31:0] samp(int f, bit ch);
    logic [31:0] w;
    w = (32'(f) * 32'h0013_5791) + (ch ? 32'h5A5A_5A00 : 32'h00C3_1E00);
    w[7:0] = 8'hA5 ^ 8'(f);
    return w;
  endfunction

  function automatic logic [3:0] nib(int fs);
    case (fs)
      1: return 4'd2;  2: return 4'd8;  3: return 4'd10;
      4: return 4'd12; 5: return 4'd14; default: return 4'd0;
    endcase
  endfunction

  function automatic logic [63:0] exp_sub(int f, bit ch, int fs);
    logic [63:0] e;
    logic [31:0] w;
    logic [23:0] a;
    logic [27:0] csw;
    logic [7:0]  pat;
    logic        cs, b, lvl;
    int          fb;
    w   = samp(f, ch);
    a   = is_under(f) ? 24'h0 : w[31:8];
    fb  = f % 192;
    csw = {4'h0, nib(fs), (ch ? 4'h2 : 4'h1), 16'h07A4};
    cs  = (fb < 28) ? csw[fb] : 1'b0;
    pat = ch ? 8'b1110_0100 : ((fb == 0) ? 8'b1110_1000 : 8'b1110_0010);
    for (int i = 0; i < 8; i++) e[i] = pat[7-i];
    lvl = 1'b0;
    for (int s = 4; s < 32; s++) begin
      if (s < 28)       b = a[s-4];
      else if (s == 30) b = cs;
      else if (s == 31) b = ^{a, cs};
      else              b = 1'b0;
      lvl = ~lvl;
      e[2*s] = lvl;
      if (b) lvl = ~lvl;
      e[2*s+1] = lvl;
    end
    return e;
  endfunction

  task automatic set_src(int f);
    logic [31:0] l, r;
    l = samp(f, 1'b0);
    r = samp(f, 1'b1);
    pair_valid = !is_under(f);
    left_in    = l;
    right_in   = r;
  endtask

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // Source: after a pair is taken, present the next frame's pair.
  initial begin
    forever begin
      @(negedge clk);
      if (src_en && pair_ready) begin
        @(posedge clk);
        #1;
        src_frame++;
        set_src(src_frame);
      end
    end
  end

  task automatic run_cfg(int r, int fs, int nframes);
    int          d;
    bit          found, prev_r, first, rdy_bad, stab_bad, exp_r, edge_bad, prv;
    logic [63:0] act, e;
    string       cstag;
    d = 1 << r;
    src_en = 1'b0;
    @(negedge clk);
    ratio_sel = 2'(r);
    rate_sel  = 3'(fs);
    rst_n     = 1'b0;
    src_frame = 0;
    set_src(0);
    repeat (3) @(negedge clk);
    check(spdif_out == 1'b0 && pair_ready == 1'b0 && underrun == 1'b0, "R1", "outputs in reset",
          {61'd0, spdif_out, pair_ready, underrun}, 64'd0);
    rst_n  = 1'b1;
    src_en = 1'b1;
    found  = 1'b0;
    prev_r = 1'b0;
    for (int k = 0; k < 40 && !found; k++) begin
      @(negedge clk);
      if (spdif_out) found = 1'b1;
      else prev_r = pair_ready;
    end
    check(found, "R1", "line rises at first B preamble", {63'd0, found}, 64'd1);
    check(prev_r, "R3", "ready before first frame", {63'd0, prev_r}, 64'd1);
    first = 1'b1;
    for (int f = 0; f < nframes; f++) begin
      rdy_bad  = 1'b0;
      stab_bad = 1'b0;
      for (int ch = 0; ch < 2; ch++) begin
        act = '0;
        for (int h = 0; h < 64; h++) begin
          for (int j = 0; j < d; j++) begin
            if (!first) @(negedge clk);
            first = 1'b0;
            if (j == 0) act[h] = spdif_out;
            else if (spdif_out != act[h]) stab_bad = 1'b1;
            if (j == 0 && ch == 0 && h == 8)
              check(underrun == is_under(f), "R12", $sformatf("underrun flag frame %0d", f),
                    {63'd0, underrun}, {63'd0, is_under(f)});
            exp_r = (ch == 1) && (h == 63) && (j == d - 1);
            if (pair_ready != exp_r) rdy_bad = 1'b1;
          end
        end
        e = exp_sub(f, ch[0], fs);
        check(act[7:0] == e[7:0], "R5", $sformatf("preamble f%0d ch%0d", f, ch), act, e);
        check(act[55:8] == e[55:8], "R6 R4", $sformatf("audio slots f%0d ch%0d", f, ch), act, e);
        edge_bad = 1'b0;
        for (int s = 4; s < 32; s++) begin
          prv = act[2*s-1];
          if (act[2*s] == prv) edge_bad = 1'b1;
          if ((act[2*s+1] != act[2*s]) != ((e[2*s+1] != e[2*s]))) edge_bad = 1'b1;
        end
        check(!edge_bad, "R7", $sformatf("cell transitions f%0d ch%0d", f, ch), act, e);
        check(act[59:56] == e[59:56], "R8", $sformatf("V/U slots f%0d ch%0d", f, ch), act, e);
        cstag = ((f % 192) >= 20 && (f % 192) < 24) ? "R10" : "R9";
        check(act[61:60] == e[61:60], cstag, $sformatf("status slot f%0d ch%0d", f, ch), act, e);
        check(act[63:62] == e[63:62], "R11", $sformatf("parity slot f%0d ch%0d", f, ch), act, e);
      end
      check(!stab_bad, "R2", $sformatf("half-cell length %0d clocks frame %0d", d, f),
            {63'd0, stab_bad}, 64'd0);
      check(!rdy_bad, "R3", $sformatf("single ready pulse frame %0d", f),
            {63'd0, rdy_bad}, 64'd0);
    end
    src_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    run_cfg(0, 5, 194);
    run_cfg(1, 0, 26);
    run_cfg(0, 1, 26);
    run_cfg(1, 2, 26);
    run_cfg(2, 3, 26);
    run_cfg(1, 4, 26);
    report();
    $finish;
  end
endmodule